// File: doc/BRIEF.md
# System Bus Access Master

This block is the part of a debug module that lets an external debugger read and write system memory without involving any processor. The debugger reaches three registers over the debug module interface (DMI): a control/status word, an address word and a data word. Accesses to those registers turn into single read or write transfers on a simple request/grant host port. The host port is 32 bits wide and carries byte enables.

The debugger chooses the transfer size (8, 16 or 32 bits) and can ask for reads to start on their own, either when it writes the address or when it reads the data word. It can also have the address advance by the transfer size after each completed transfer. Misaligned and oversized requests are refused, and a sticky error code records the cause. A request that arrives while a transfer is still outstanding sets a separate sticky busy-error flag. When the debug-enable input is low, no request ever appears on the host port.

Top module: `sysbus_dbg_master`

## Requirements
- R1: After reset, the control word (DMI offset 0x38) reads 0x20040407: version 1 in [31:29], busy-error [22]=0, busy [21]=0, read-on-address [20]=0, size [19:17]=2, auto-increment [16]=0, read-on-data [15]=0, error code [14:12]=0, address width 32 in [11:5], size support mask 0b00111 in [4:0]. The address word (0x39) and data word (0x3C) read 0, and no bus request is raised.
- R2: Writing the data word starts a bus write at the current address with size code 0=8, 1=16, 2=32 bits. Narrow data is replicated across all byte lanes, and only the addressed lanes have their byte enable set.
- R3: With read-on-address set, writing the address word starts a bus read at the new address. The returned data is stored in the data word right-aligned to the access size and zero-extended.
- R4: With read-on-data set, a DMI read of the data word returns its current value and starts a bus read. With read-on-data clear, the same read starts nothing.
- R5: An access whose address is not a multiple of the transfer size is not issued, and the error code becomes 3.
- R6: An access with a size code above 2 is not issued, and the error code becomes 4. The size check takes precedence over the alignment check.
- R7: Busy [21] reads 1 from the cycle after an access is issued until its response returns. A write of the address or data word, or a read of the data word, made while busy sets busy-error [22], starts nothing, and the write is discarded.
- R8: Busy-error and the error code clear by writing 1 to them. While either is set, no new access starts.
- R9: With auto-increment set, each completed access adds the transfer size in bytes to the address word.
- R10: While debug-enable is low, the bus request stays low. Triggers are dropped without setting an error. A request not yet granted is withdrawn and busy clears.
- R11: An error flag on the response is ignored. The access completes, busy clears and the error code stays 0.
- R12: Once raised, the bus request and its address stay unchanged until the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_en | input | 1 | Debug enable; low blocks all bus traffic |
| dmi_req | input | 1 | DMI access strobe, one cycle per access |
| dmi_we | input | 1 | DMI access is a write |
| dmi_addr | input | 7 | DMI register offset |
| dmi_wdata | input | 32 | DMI write data |
| dmi_rdata | output | 32 | DMI read data for the offset on dmi_addr |
| bus_req | output | 1 | Host port request |
| bus_we | output | 1 | Host port write |
| bus_addr | output | 32 | Host port byte address |
| bus_wdata | output | 32 | Host port write data, lane-replicated |
| bus_be | output | 4 | Host port byte enables |
| bus_gnt | input | 1 | Grant for the current request |
| bus_rvalid | input | 1 | Response valid |
| bus_rdata | input | 32 | Response read data |
| bus_err | input | 1 | Response error flag (ignored) |

## Verification
The hardest case to reach from the ports is an access that arrives while an earlier one is still outstanding. With an immediate grant the window lasts only two cycles. The bench therefore holds the grant low, so the first request stays pending. It then issues a second data write and checks three things: the busy-error flag is set, only the first transfer reaches memory, and the request address did not move while it waited. The same stall is used to withdraw a pending request by dropping debug-enable.

// File: rtl/sbm_pkg.sv
`timescale 1ns/1ps
package sbm_pkg;
    localparam int BUS_W  = 32;
    localparam int BYTES  = BUS_W / 8;
    localparam int LANE_W = $clog2(BYTES);
    localparam int SIZE_W = $clog2(LANE_W + 1);
    localparam int ADDR_W = 32;
    localparam int DMI_AW = 7;

    localparam logic [DMI_AW-1:0] REG_CTRL = 7'h38;
    localparam logic [DMI_AW-1:0] REG_ADDR = 7'h39;
    localparam logic [DMI_AW-1:0] REG_DATA = 7'h3C;

    localparam logic [2:0] SB_VERSION   = 3'd1;
    localparam logic [2:0] ERR_MISALIGN = 3'd3;
    localparam logic [2:0] ERR_SIZE     = 3'd4;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_REQ,
        BUS_WAIT
    } bus_state_e;

    typedef struct packed {
        logic       rd_on_addr;
        logic [2:0] access;
        logic       auto_inc;
        logic       rd_on_data;
    } sb_ctrl_t;

    typedef struct packed {
        logic              we;
        logic [SIZE_W-1:0] size;
        logic [ADDR_W-1:0] addr;
        logic [BUS_W-1:0]  wdata;
    } bus_cmd_t;

    // number of bytes moved by one transfer of the given size code
    function automatic logic [LANE_W:0] size_bytes(logic [SIZE_W-1:0] sz);
        return (LANE_W + 1)'(1) << sz;
    endfunction

    function automatic logic size_supported(logic [2:0] access);
        return int'(access) <= LANE_W;
    endfunction

    function automatic logic is_aligned(logic [ADDR_W-1:0] a, logic [SIZE_W-1:0] sz);
        logic [LANE_W:0] n;
        n = size_bytes(sz);
        return (a[LANE_W-1:0] & (n[LANE_W-1:0] - LANE_W'(1))) == '0;
    endfunction

    function automatic logic [4:0] support_mask();
        logic [4:0] m;
        m = '0;
        for (int i = 0; i <= LANE_W; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] pack_ctrl(sb_ctrl_t c, logic busy_err,
                                              logic busy, logic [2:0] err);
        return {SB_VERSION, 6'b0, busy_err, busy, c.rd_on_addr, c.access,
                c.auto_inc, c.rd_on_data, err, 7'(ADDR_W), support_mask()};
    endfunction
endpackage

// File: rtl/sbm_lane_fmt.sv
`timescale 1ns/1ps
module sbm_lane_fmt
    import sbm_pkg::*;
(
    input  logic [SIZE_W-1:0] size,
    input  logic [LANE_W-1:0] offset,
    input  logic [BUS_W-1:0]  wdata_in,
    input  logic [BUS_W-1:0]  rdata_in,
    output logic [BUS_W-1:0]  wdata_out,
    output logic [BYTES-1:0]  be_out,
    output logic [BUS_W-1:0]  rdata_out
);
    logic [LANE_W:0]   nbytes;
    logic [LANE_W:0]   lane_end;
    logic [LANE_W-1:0] rep_mask;

    assign nbytes   = size_bytes(size);
    assign lane_end = {1'b0, offset} + nbytes;
    assign rep_mask = nbytes[LANE_W-1:0] - LANE_W'(1);

    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        localparam logic [LANE_W:0] IDX = (LANE_W + 1)'(i);
        logic [LANE_W-1:0] src_w;
        logic [LANE_W-1:0] src_r;

        // write side: lane i carries byte (i mod size) of the debugger data
        assign src_w = IDX[LANE_W-1:0] & rep_mask;
        assign wdata_out[8*i +: 8] = wdata_in[{src_w, 3'b000} +: 8];
        assign be_out[i] = (IDX >= {1'b0, offset}) && (IDX < lane_end);

        // read side: output byte i comes from lane offset+i, zero above size
        assign src_r = offset + IDX[LANE_W-1:0];
        assign rdata_out[8*i +: 8] = (IDX < nbytes) ? rdata_in[{src_r, 3'b000} +: 8] : 8'h00;
    end
endmodule

// File: rtl/sbm_bus_eng.sv
`timescale 1ns/1ps
module sbm_bus_eng
    import sbm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     dbg_en,
    input  logic     start,
    input  bus_cmd_t start_cmd,
    input  logic     bus_gnt,
    input  logic     bus_rvalid,
    output logic     bus_req,
    output logic     busy,
    output logic     done,
    output logic     rd_valid,
    output bus_cmd_t cmd_q
);
    bus_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BUS_IDLE: if (start) st_d = BUS_REQ;
            BUS_REQ: begin
                if (!dbg_en)      st_d = BUS_IDLE;   // withdraw, nothing left on the port
                else if (bus_gnt) st_d = BUS_WAIT;
            end
            BUS_WAIT: if (bus_rvalid) st_d = BUS_IDLE; // error flag plays no part
            default: st_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= BUS_IDLE;
            cmd_q <= '0;
        end else begin
            st_q <= st_d;
            if (start && st_q == BUS_IDLE) cmd_q <= start_cmd;
        end
    end

    assign bus_req  = (st_q == BUS_REQ) && dbg_en;
    assign busy     = (st_q != BUS_IDLE);
    assign done     = (st_q == BUS_WAIT) && bus_rvalid;
    assign rd_valid = done && !cmd_q.we;
endmodule

// File: rtl/sbm_regs.sv
`timescale 1ns/1ps
module sbm_regs
    import sbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_en,
    input  logic              dmi_req,
    input  logic              dmi_we,
    input  logic [DMI_AW-1:0] dmi_addr,
    input  logic [31:0]       dmi_wdata,
    output logic [31:0]       dmi_rdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic              eng_rd_valid,
    input  logic [BUS_W-1:0]  eng_rd_data,
    input  logic [SIZE_W-1:0] eng_size,
    output logic              start,
    output bus_cmd_t          start_cmd
);
    sb_ctrl_t          ctrl_q;
    logic              busy_err_q;
    logic [2:0]        err_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BUS_W-1:0]  data_q;

    logic wr_ctrl, wr_addr, wr_data, rd_data, touch, trig;
    logic set_busy_err, set_err;
    logic [2:0] err_code;

    assign wr_ctrl = dmi_req &&  dmi_we && dmi_addr == REG_CTRL;
    assign wr_addr = dmi_req &&  dmi_we && dmi_addr == REG_ADDR;
    assign wr_data = dmi_req &&  dmi_we && dmi_addr == REG_DATA;
    assign rd_data = dmi_req && !dmi_we && dmi_addr == REG_DATA;
    assign touch   = wr_addr || wr_data || rd_data;
    assign trig    = wr_data || (wr_addr && ctrl_q.rd_on_addr) || (rd_data && ctrl_q.rd_on_data);

    // decide in the cycle of the DMI access: refuse, flag or launch
    always_comb begin
        start           = 1'b0;
        set_busy_err    = 1'b0;
        set_err         = 1'b0;
        err_code        = '0;
        start_cmd.we    = wr_data;
        start_cmd.size  = ctrl_q.access[SIZE_W-1:0];
        start_cmd.addr  = wr_addr ? ADDR_W'(dmi_wdata) : addr_q;
        start_cmd.wdata = BUS_W'(dmi_wdata);
        if (touch && eng_busy) begin
            set_busy_err = 1'b1;
        end else if (trig && dbg_en && err_q == '0 && !busy_err_q) begin
            if (!size_supported(ctrl_q.access)) begin
                set_err  = 1'b1;
                err_code = ERR_SIZE;
            end else if (!is_aligned(start_cmd.addr, start_cmd.size)) begin
                set_err  = 1'b1;
                err_code = ERR_MISALIGN;
            end else begin
                start = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '{rd_on_addr: 1'b0, access: 3'(LANE_W), auto_inc: 1'b0, rd_on_data: 1'b0};
            busy_err_q <= 1'b0;
            err_q      <= '0;
            addr_q     <= '0;
            data_q     <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.rd_on_addr <= dmi_wdata[20];
                ctrl_q.access     <= dmi_wdata[19:17];
                ctrl_q.auto_inc   <= dmi_wdata[16];
                ctrl_q.rd_on_data <= dmi_wdata[15];
                if (dmi_wdata[22]) busy_err_q <= 1'b0;
                err_q <= err_q & ~dmi_wdata[14:12];
            end
            if (set_busy_err) busy_err_q <= 1'b1;
            if (set_err)      err_q      <= err_code;

            if (wr_addr && !eng_busy)
                addr_q <= ADDR_W'(dmi_wdata);
            else if (eng_done && ctrl_q.auto_inc)
                addr_q <= addr_q + ADDR_W'(size_bytes(eng_size));

            if (wr_data && !eng_busy)
                data_q <= BUS_W'(dmi_wdata);
            else if (eng_rd_valid)
                data_q <= eng_rd_data;
        end
    end

    always_comb begin
        unique case (dmi_addr)
            REG_CTRL: dmi_rdata = pack_ctrl(ctrl_q, busy_err_q, eng_busy, err_q);
            REG_ADDR: dmi_rdata = 32'(addr_q);
            REG_DATA: dmi_rdata = 32'(data_q);
            default:  dmi_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sysbus_dbg_master.sv
`timescale 1ns/1ps
module sysbus_dbg_master
    import sbm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        dbg_en,
    input  logic        dmi_req,
    input  logic        dmi_we,
    input  logic [6:0]  dmi_addr,
    input  logic [31:0] dmi_wdata,
    output logic [31:0] dmi_rdata,
    output logic        bus_req,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    output logic [3:0]  bus_be,
    input  logic        bus_gnt,
    input  logic        bus_rvalid,
    input  logic [31:0] bus_rdata,
    input  logic        bus_err
);
    logic             start;
    bus_cmd_t         start_cmd;
    bus_cmd_t         cmd_q;
    logic             eng_busy, eng_done, eng_rd_valid;
    logic [BUS_W-1:0] rd_aligned;
    logic             unused_bus_err;

    assign unused_bus_err = bus_err;   // responses complete regardless of this flag

    sbm_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .dbg_en       (dbg_en),
        .dmi_req      (dmi_req),
        .dmi_we       (dmi_we),
        .dmi_addr     (dmi_addr),
        .dmi_wdata    (dmi_wdata),
        .dmi_rdata    (dmi_rdata),
        .eng_busy     (eng_busy),
        .eng_done     (eng_done),
        .eng_rd_valid (eng_rd_valid),
        .eng_rd_data  (rd_aligned),
        .eng_size     (cmd_q.size),
        .start        (start),
        .start_cmd    (start_cmd)
    );

    sbm_bus_eng u_eng (
        .clk        (clk),
        .rst        (rst),
        .dbg_en     (dbg_en),
        .start      (start),
        .start_cmd  (start_cmd),
        .bus_gnt    (bus_gnt),
        .bus_rvalid (bus_rvalid),
        .bus_req    (bus_req),
        .busy       (eng_busy),
        .done       (eng_done),
        .rd_valid   (eng_rd_valid),
        .cmd_q      (cmd_q)
    );

    sbm_lane_fmt u_lane (
        .size      (cmd_q.size),
        .offset    (cmd_q.addr[LANE_W-1:0]),
        .wdata_in  (cmd_q.wdata),
        .rdata_in  (bus_rdata),
        .wdata_out (bus_wdata),
        .be_out    (bus_be),
        .rdata_out (rd_aligned)
    );

    assign bus_we   = cmd_q.we;
    assign bus_addr = cmd_q.addr;
endmodule

// File: rtl/sbm_checker.sv
`timescale 1ns/1ps
module sbm_checker (
    input logic        clk,
    input logic        rst,
    input logic        dbg_en,
    input logic        bus_req,
    input logic        bus_gnt,
    input logic        bus_rvalid,
    input logic [31:0] bus_addr,
    input logic [3:0]  bus_be,
    input logic        eng_busy
);
    assert_no_req_disabled_R10: assert property (@(posedge clk) disable iff (rst)
        !dbg_en |-> !bus_req);

    assert_req_held_R12: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt && dbg_en) |=> (bus_req || !dbg_en) && $stable(bus_addr));

    assert_lane_pattern_R2: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (bus_be inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF}));

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> !$past(eng_busy));

    assert_busy_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (eng_busy && !bus_rvalid && dbg_en) |=> eng_busy);

    assert_resp_completes_R11: assert property (@(posedge clk) disable iff (rst)
        (eng_busy && !bus_req && bus_rvalid) |=> !eng_busy);
endmodule

bind sysbus_dbg_master sbm_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .dbg_en     (dbg_en),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .bus_rvalid (bus_rvalid),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .eng_busy   (eng_busy)
);

// File: tb/sysbus_dbg_master_bench.sv
`timescale 1ns/1ps
module sysbus_dbg_master_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dbg_en = 1'b1;
    logic        dmi_req = 1'b0, dmi_we = 1'b0;
    logic [6:0]  dmi_addr = '0;
    logic [31:0] dmi_wdata = '0;
    logic [31:0] dmi_rdata;
    logic        bus_req, bus_we, bus_gnt, bus_rvalid, bus_err;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [3:0]  bus_be;

    logic        stall = 1'b0, err_inj = 1'b0, req_off = 1'b0;
    int          txn = 0;
    logic        last_we;
    logic [31:0] last_addr, last_wdata;
    logic [3:0]  last_be;
    logic [31:0] mem [64];

    int errors = 0, checks = 0;
    bit finished = 1'b0;

    localparam logic [6:0] A_CTRL = 7'h38, A_ADDR = 7'h39, A_DATA = 7'h3C;

    typedef struct packed {
        logic [1:0]  size;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        logic [31:0] lane;
        logic [31:0] rd;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{2'd2, 32'h10, 32'hA1B2C3D4, 4'hF, 32'hA1B2C3D4, 32'hA1B2C3D4},
        '{2'd0, 32'h21, 32'h0000005A, 4'h2, 32'h5A5A5A5A, 32'h0000005A},
        '{2'd1, 32'h32, 32'h0000BEEF, 4'hC, 32'hBEEFBEEF, 32'h0000BEEF},
        '{2'd0, 32'h43, 32'h00000077, 4'h8, 32'h77777777, 32'h00000077},
        '{2'd1, 32'h50, 32'h00001234, 4'h3, 32'h12341234, 32'h00001234}
    };

    sysbus_dbg_master u_sysbus_dbg_master (
        .clk(clk), .rst(rst), .dbg_en(dbg_en),
        .dmi_req(dmi_req), .dmi_we(dmi_we), .dmi_addr(dmi_addr),
        .dmi_wdata(dmi_wdata), .dmi_rdata(dmi_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_gnt(bus_gnt),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    always #2.5 clk = ~clk;

    assign bus_gnt = bus_req && !stall;

    // memory model: grant when not stalled, respond one cycle after grant
    always @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_err    <= 1'b0;
            bus_rdata  <= '0;
            txn        <= 0;
            req_off    <= 1'b0;
            for (int i = 0; i < 64; i++) mem[i] <= '0;
        end else begin
            bus_rvalid <= bus_req && bus_gnt;
            bus_err    <= err_inj && bus_req && bus_gnt;
            if (bus_req && !dbg_en) req_off <= 1'b1;
            if (bus_req && bus_gnt) begin
                txn        <= txn + 1;
                last_we    <= bus_we;
                last_addr  <= bus_addr;
                last_be    <= bus_be;
                last_wdata <= bus_wdata;
                bus_rdata  <= mem[bus_addr[7:2]];
                if (bus_we)
                    for (int b = 0; b < 4; b++)
                        if (bus_be[b]) mem[bus_addr[7:2]][8*b +: 8] <= bus_wdata[8*b +: 8];
            end
        end
    end

    function automatic logic [31:0] ctl(int size, bit roa, bit ai, bit rod);
        return (32'(size) << 17) | (32'(roa) << 20) | (32'(ai) << 16) | (32'(rod) << 15);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic dmi_write(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        dmi_req = 1'b1; dmi_we = 1'b1; dmi_addr = a; dmi_wdata = d;
        @(negedge clk);
        dmi_req = 1'b0; dmi_we = 1'b0;
    endtask

    task automatic dmi_read(logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        dmi_req = 1'b1; dmi_we = 1'b0; dmi_addr = a;
        #1 d = dmi_rdata;
        @(negedge clk);
        dmi_req = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int k = 0; k < 50; k++) begin
            dmi_read(A_CTRL, s);
            if (!s[21]) break;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        int n0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        dmi_read(A_CTRL, r); chk("R1 ctrl", r, 32'h20040407);
        dmi_read(A_ADDR, r); chk("R1 addr", r, 32'h0);
        dmi_read(A_DATA, r); chk("R1 data", r, 32'h0);
        chk("R1 req", 32'(bus_req), 32'h0);

        // vector table: R2 write lanes, R3 read-on-address right-aligned
        foreach (VEC[i]) begin
            dmi_write(A_CTRL, ctl(VEC[i].size, 0, 0, 0));
            dmi_write(A_ADDR, VEC[i].addr);
            dmi_write(A_DATA, VEC[i].data);
            wait_idle();
            chk("R2 we", 32'(last_we), 32'h1);
            chk("R2 addr", last_addr, VEC[i].addr);
            chk("R2 be", 32'(last_be), 32'(VEC[i].be));
            chk("R2 wdata", last_wdata, VEC[i].lane);
            dmi_write(A_CTRL, ctl(VEC[i].size, 1, 0, 0));
            dmi_write(A_ADDR, VEC[i].addr);
            wait_idle();
            chk("R3 we", 32'(last_we), 32'h0);
            dmi_read(A_DATA, r); chk("R3 rdata", r, VEC[i].rd);
        end

        // R5 misaligned, R8 error blocks and clears
        dmi_write(A_CTRL, ctl(2, 0, 0, 0));
        dmi_write(A_ADDR, 32'h12);
        n0 = txn;
        dmi_write(A_DATA, 32'h55);
        repeat (3) @(negedge clk);
        dmi_read(A_CTRL, r); chk("R5 code", 32'(r[14:12]), 32'd3);
        chk("R5 no txn", 32'(txn), 32'(n0));
        dmi_write(A_ADDR, 32'h10);
        dmi_write(A_DATA, 32'h66);
        repeat (3) @(negedge clk);
        chk("R8 blocked by error", 32'(txn), 32'(n0));
        dmi_write(A_CTRL, ctl(2, 0, 0, 0) | 32'h7000);
        dmi_read(A_CTRL, r); chk("R8 error cleared", 32'(r[14:12]), 32'd0);

        // R6 oversize, precedence over misalignment
        dmi_write(A_CTRL, ctl(3, 0, 0, 0));
        dmi_write(A_ADDR, 32'h11);
        dmi_write(A_DATA, 32'h1);
        repeat (3) @(negedge clk);
        dmi_read(A_CTRL, r); chk("R6 code", 32'(r[14:12]), 32'd4);
        chk("R6 no txn", 32'(txn), 32'(n0));
        dmi_write(A_CTRL, ctl(2, 0, 0, 0) | 32'h7000);

        // R7 busy and busy-error under a stalled grant, R12 held request
        stall = 1'b1;
        dmi_write(A_ADDR, 32'h80);
        dmi_write(A_DATA, 32'h11111111);
        dmi_read(A_CTRL, r); chk("R7 busy set", 32'(r[21]), 32'h1);
        repeat (3) @(negedge clk);
        chk("R12 req held", 32'(bus_req), 32'h1);
        chk("R12 addr held", bus_addr, 32'h80);
        dmi_write(A_DATA, 32'h22222222);
        dmi_read(A_CTRL, r); chk("R7 busy error", 32'(r[22]), 32'h1);
        stall = 1'b0;
        wait_idle();
        chk("R7 one txn", 32'(txn), 32'(n0 + 1));
        chk("R7 second discarded", last_wdata, 32'h11111111);
        dmi_read(A_DATA, r); chk("R7 data kept", r, 32'h11111111);
        dmi_write(A_DATA, 32'h33);
        repeat (3) @(negedge clk);
        chk("R8 blocked by busy error", 32'(txn), 32'(n0 + 1));
        dmi_write(A_CTRL, ctl(2, 0, 0, 0) | 32'h0040_0000);
        dmi_read(A_CTRL, r); chk("R8 busy error cleared", 32'(r[22]), 32'h0);

        // R9 auto-increment with 16-bit writes
        dmi_write(A_CTRL, ctl(1, 0, 1, 0));
        dmi_write(A_ADDR, 32'h60);
        dmi_write(A_DATA, 32'hAAAA); wait_idle(); chk("R9 first", last_addr, 32'h60);
        dmi_write(A_DATA, 32'hBBBB); wait_idle(); chk("R9 second", last_addr, 32'h62);
        dmi_write(A_DATA, 32'hCCCC); wait_idle(); chk("R9 third", last_addr, 32'h64);
        dmi_read(A_ADDR, r); chk("R9 final addr", r, 32'h66);

        // R4 read-on-data chained with read-on-address and auto-increment
        dmi_write(A_CTRL, ctl(2, 0, 0, 0));
        dmi_write(A_ADDR, 32'h14);
        dmi_write(A_DATA, 32'hCAFEF00D); wait_idle();
        dmi_write(A_CTRL, ctl(2, 1, 1, 1));
        dmi_write(A_ADDR, 32'h10); wait_idle();
        dmi_read(A_ADDR, r); chk("R9 after read", r, 32'h14);
        dmi_read(A_DATA, r); chk("R4 returns current", r, 32'hA1B2C3D4);
        wait_idle();
        chk("R4 read issued", last_addr, 32'h14);
        dmi_read(A_ADDR, r); chk("R4 addr advanced", r, 32'h18);
        dmi_write(A_CTRL, ctl(2, 0, 0, 0));
        n0 = txn;
        dmi_read(A_DATA, r); chk("R4 new data", r, 32'hCAFEF00D);
        repeat (3) @(negedge clk);
        chk("R4 no trigger when clear", 32'(txn), 32'(n0));

        // R10 debug disabled: no traffic, no error, pending request withdrawn
        dbg_en = 1'b0;
        dmi_write(A_ADDR, 32'h90);
        dmi_write(A_DATA, 32'h99);
        repeat (4) @(negedge clk);
        chk("R10 no txn", 32'(txn), 32'(n0));
        dmi_read(A_CTRL, r); chk("R10 no error", 32'(r[14:12]), 32'd0);
        dbg_en = 1'b1;
        stall = 1'b1;
        dmi_write(A_DATA, 32'h98);
        @(negedge clk) dbg_en = 1'b0;
        @(negedge clk);
        dmi_read(A_CTRL, r); chk("R10 withdrawn", 32'(r[21]), 32'h0);
        dbg_en = 1'b1; stall = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 not resumed", 32'(txn), 32'(n0));
        chk("R10 no req while off", 32'(req_off), 32'h0);

        // R11 bus error flag ignored
        err_inj = 1'b1;
        dmi_write(A_ADDR, 32'h84);
        dmi_write(A_DATA, 32'h4242);
        wait_idle();
        err_inj = 1'b0;
        dmi_read(A_CTRL, r);
        chk("R11 completed", 32'(r[21]), 32'h0);
        chk("R11 no error", 32'(r[14:12]), 32'd0);
        chk("R11 txn", 32'(txn), 32'(n0 + 1));

        finish_run();
    end
endmodule